// File: doc/BRIEF.md
# Polyline Vertex Stream Parser

This block sits between a drawing-command decoder and a line rasterizer. After the decoder sees a polyline command, it pulses a start strobe. The strobe carries the shading kind (flat or Gouraud) and, for flat shading, the single colour of the whole line. The parser then takes the words that follow the command over a valid/ready handshake. It groups them into vertices and issues one segment request for each pair of consecutive vertices.

In Gouraud mode a vertex is two words: a colour word, then a position word. In flat mode a vertex is a single position word. The list ends on a terminator word, recognised by a fixed nibble pattern in the word that opens a vertex slot. The terminator is only honoured once two vertices have arrived. A segment whose two endpoints coincide is flagged so that the rasterizer fills a single pixel instead of drawing a line.

Top module: `polyline_parser`

## Requirements
- R1: A position word carries signed X in bits 15:0 and signed Y in bits 31:16. A segment starts at the previous vertex (x0/y0) and ends at the newly received vertex (x1/y1).
- R2: In Gouraud mode each vertex is a colour word (colour in bits 23:0) followed by a position word. seg_c0 is the previous vertex's colour and seg_c1 is the new vertex's colour.
- R3: In flat mode each vertex is one position word, and both colours of every segment equal the colour given with the start strobe.
- R4: Every vertex after the first produces exactly one segment request, so N vertices give N-1 segments. The request appears on seg_valid in the cycle after the handshake that accepted the vertex's position word. The first vertex produces no request.
- R5: A word with (word & 0xF000F000) == 0x50005000, arriving as the first word of a vertex slot after at least two vertices, ends the list. It is consumed and produces no segment.
- R6: A terminator-pattern word that arrives before the second vertex is complete is taken as ordinary vertex data.
- R7: In Gouraud mode the pattern test applies only to the colour word; a position word that matches the pattern is an ordinary position.
- R8: When both endpoints of a segment are equal, seg_point is 1 and both colours equal the first vertex's colour. When the endpoints differ, seg_point is 0.
- R9: While a segment request waits for seg_ready, in_ready is 0 and all segment outputs hold their values.
- R10: After the terminator is consumed, in_ready stays 0 until a new start strobe. After a start strobe, in_ready is 1 in the next cycle.
- R11: After reset, in_ready and seg_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Pulse that opens a new vertex list (accepted when idle) |
| cmd_gouraud | input | 1 | Shading kind with the start strobe: 1 Gouraud, 0 flat |
| cmd_color | input | COLOR_W | Flat colour supplied with the start strobe |
| in_data | input | 32 | Vertex stream word |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Parser accepts in_data this cycle |
| seg_valid | output | 1 | Segment request pending |
| seg_ready | input | 1 | Rasterizer takes the segment |
| seg_x0 | output | 16 | Start X, signed |
| seg_y0 | output | 16 | Start Y, signed |
| seg_x1 | output | 16 | End X, signed |
| seg_y1 | output | 16 | End Y, signed |
| seg_c0 | output | COLOR_W | Start colour |
| seg_c1 | output | COLOR_W | End colour |
| seg_point | output | 1 | Fill one pixel instead of drawing a line |

## Verification
Every cycle, the assertions check the output handshake: a pending request blocks input and holds its fields stable. They check that the point flag agrees with the endpoint geometry and colours, and that a new request only follows an accepted input word. The order of the vertices and the effect of the mode on colours can only be shown by the bench's scenarios, which compare each request against a model. The same applies to when the terminator pattern counts and when it is plain data, and to the return to idle.

// File: rtl/polyline_pkg.sv
// Shared constants and types for the polyline parser.
// Assumes a 32-bit stream word split into two 16-bit coordinates.
package polyline_pkg;
    localparam int WORD_W  = 32;
    localparam int COORD_W = WORD_W / 2;
    localparam logic [WORD_W-1:0] END_MASK  = 32'hF000_F000;
    localparam logic [WORD_W-1:0] END_MATCH = 32'h5000_5000;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_COLOR = 2'd1,
        PS_POS   = 2'd2
    } pstate_t;
endpackage

// File: rtl/pl_word_decode.sv
// Splits a stream word into its possible meanings: end marker, coordinates, colour.
// Purely combinational; the sequencer decides which meaning applies.
module pl_word_decode
    import polyline_pkg::*;
#(
    parameter int COLOR_W = 24
) (
    input  logic [WORD_W-1:0]  word,
    output logic               is_end,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y,
    output logic [COLOR_W-1:0] color
);
    // Classify and slice the word.
    always_comb begin
        is_end = (word & END_MASK) == END_MATCH;
        pos_x  = word[COORD_W-1:0];
        pos_y  = word[WORD_W-1:COORD_W];
        color  = word[COLOR_W-1:0];
    end
endmodule

// File: rtl/pl_seq.sv
// Vertex-slot sequencer: tracks which word of a slot is expected, counts
// vertices, honours the end marker only once MIN_VERTS vertices are in.
// Assumes seg_busy is high for as long as a segment request is pending.
module pl_seq
    import polyline_pkg::*;
#(
    parameter int MIN_VERTS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_gouraud,
    input  logic in_valid,
    input  logic is_end,
    input  logic seg_busy,
    output logic in_ready,
    output logic list_open,
    output logic take_color,
    output logic take_pos,
    output logic have_prev
);
    localparam int CNT_W = $clog2(MIN_VERTS + 1);

    pstate_t          state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             gouraud_q;
    logic             accept;
    logic             enough;

    // Handshake and slot decisions.
    always_comb begin
        in_ready   = (state_q != PS_IDLE) && !seg_busy;
        accept     = in_valid && in_ready;
        enough     = cnt_q >= CNT_W'(MIN_VERTS);
        list_open  = (state_q == PS_IDLE) && cmd_start;
        have_prev  = cnt_q != '0;
        take_color = 1'b0;
        take_pos   = 1'b0;
        state_d    = state_q;
        case (state_q)
            PS_IDLE: if (cmd_start) state_d = cmd_gouraud ? PS_COLOR : PS_POS;
            PS_COLOR: if (accept) begin
                if (is_end && enough) state_d = PS_IDLE;
                else begin
                    take_color = 1'b1;
                    state_d    = PS_POS;
                end
            end
            PS_POS: if (accept) begin
                if (!gouraud_q && is_end && enough) state_d = PS_IDLE;
                else begin
                    take_pos = 1'b1;
                    state_d  = gouraud_q ? PS_COLOR : PS_POS;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    // State, shading kind and saturating vertex count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PS_IDLE;
            cnt_q     <= '0;
            gouraud_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (list_open) begin
                cnt_q     <= '0;
                gouraud_q <= cmd_gouraud;
            end else if (take_pos && !enough) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pl_seg_out.sv
// Holds the previous vertex and current colour and issues the segment request.
// Assumes take_pos only arrives while no request is pending.
module pl_seg_out
    import polyline_pkg::*;
#(
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               list_open,
    input  logic [COLOR_W-1:0] cmd_color,
    input  logic               take_color,
    input  logic               take_pos,
    input  logic               have_prev,
    input  logic [COORD_W-1:0] new_x,
    input  logic [COORD_W-1:0] new_y,
    input  logic [COLOR_W-1:0] new_color,
    input  logic               seg_ready,
    output logic               seg_valid,
    output logic [COORD_W-1:0] seg_x0,
    output logic [COORD_W-1:0] seg_y0,
    output logic [COORD_W-1:0] seg_x1,
    output logic [COORD_W-1:0] seg_y1,
    output logic [COLOR_W-1:0] seg_c0,
    output logic [COLOR_W-1:0] seg_c1,
    output logic               seg_point
);
    logic [COLOR_W-1:0] cur_c_q, prev_c_q;
    logic [COORD_W-1:0] prev_x_q, prev_y_q;
    logic               same;

    // Zero-length test between the stored and the incoming vertex.
    always_comb same = (prev_x_q == new_x) && (prev_y_q == new_y);

    // Vertex memory: colour of the slot in progress and the last full vertex.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_c_q  <= '0;
            prev_c_q <= '0;
            prev_x_q <= '0;
            prev_y_q <= '0;
        end else begin
            if (list_open)       cur_c_q <= cmd_color;
            else if (take_color) cur_c_q <= new_color;
            if (take_pos) begin
                prev_x_q <= new_x;
                prev_y_q <= new_y;
                prev_c_q <= cur_c_q;
            end
        end
    end

    // Segment request register, held until the rasterizer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_valid <= 1'b0;
            seg_x0    <= '0;
            seg_y0    <= '0;
            seg_x1    <= '0;
            seg_y1    <= '0;
            seg_c0    <= '0;
            seg_c1    <= '0;
            seg_point <= 1'b0;
        end else if (take_pos && have_prev) begin
            seg_valid <= 1'b1;
            seg_x0    <= prev_x_q;
            seg_y0    <= prev_y_q;
            seg_x1    <= new_x;
            seg_y1    <= new_y;
            seg_c0    <= prev_c_q;
            seg_c1    <= same ? prev_c_q : cur_c_q;
            seg_point <= same;
        end else if (seg_ready) begin
            seg_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/polyline_parser.sv
// Polyline vertex stream parser top: decode, sequence, emit segments.
// Assumes the command decoder pulses cmd_start only between lists.
module polyline_parser
    import polyline_pkg::*;
#(
    parameter int COLOR_W   = 24,
    parameter int MIN_VERTS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic               cmd_gouraud,
    input  logic [COLOR_W-1:0] cmd_color,
    input  logic [WORD_W-1:0]  in_data,
    input  logic               in_valid,
    output logic               in_ready,
    output logic               seg_valid,
    input  logic               seg_ready,
    output logic [COORD_W-1:0] seg_x0,
    output logic [COORD_W-1:0] seg_y0,
    output logic [COORD_W-1:0] seg_x1,
    output logic [COORD_W-1:0] seg_y1,
    output logic [COLOR_W-1:0] seg_c0,
    output logic [COLOR_W-1:0] seg_c1,
    output logic               seg_point
);
    logic               is_end, list_open, take_color, take_pos, have_prev;
    logic [COORD_W-1:0] dec_x, dec_y;
    logic [COLOR_W-1:0] dec_c;

    pl_word_decode #(.COLOR_W(COLOR_W)) u_dec (
        .word  (in_data),
        .is_end(is_end),
        .pos_x (dec_x),
        .pos_y (dec_y),
        .color (dec_c)
    );

    pl_seq #(.MIN_VERTS(MIN_VERTS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_gouraud(cmd_gouraud),
        .in_valid   (in_valid),
        .is_end     (is_end),
        .seg_busy   (seg_valid),
        .in_ready   (in_ready),
        .list_open  (list_open),
        .take_color (take_color),
        .take_pos   (take_pos),
        .have_prev  (have_prev)
    );

    pl_seg_out #(.COLOR_W(COLOR_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .list_open (list_open),
        .cmd_color (cmd_color),
        .take_color(take_color),
        .take_pos  (take_pos),
        .have_prev (have_prev),
        .new_x     (dec_x),
        .new_y     (dec_y),
        .new_color (dec_c),
        .seg_ready (seg_ready),
        .seg_valid (seg_valid),
        .seg_x0    (seg_x0),
        .seg_y0    (seg_y0),
        .seg_x1    (seg_x1),
        .seg_y1    (seg_y1),
        .seg_c0    (seg_c0),
        .seg_c1    (seg_c1),
        .seg_point (seg_point)
    );
endmodule

// File: rtl/polyline_parser_chk.sv
// Port-level checker for polyline_parser, attached by bind below.
// Assumes reset is synchronous and active low.
module polyline_parser_chk #(
    parameter int COLOR_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               seg_valid,
    input logic               seg_ready,
    input logic [15:0]        seg_x0,
    input logic [15:0]        seg_y0,
    input logic [15:0]        seg_x1,
    input logic [15:0]        seg_y1,
    input logic [COLOR_W-1:0] seg_c0,
    input logic [COLOR_W-1:0] seg_c1,
    input logic               seg_point
);
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> !in_ready); // R9
    AST_SEG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid &&
        $stable({seg_x0, seg_y0, seg_x1, seg_y1, seg_c0, seg_c1, seg_point})); // R9
    AST_POINT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && seg_point |-> seg_x0 == seg_x1 && seg_y0 == seg_y1 && seg_c0 == seg_c1); // R8
    AST_LINE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_point |-> seg_x0 != seg_x1 || seg_y0 != seg_y1); // R8
    AST_SEG_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seg_valid) |-> $past(in_valid && in_ready)); // R4
endmodule

bind polyline_parser polyline_parser_chk #(.COLOR_W(COLOR_W)) u_chk (.*);

// File: tb/polyline_parser_test.sv
`timescale 1ns/1ps
module polyline_parser_test;
    logic        clk = 0, rst_n = 0;
    logic        cmd_start = 0, cmd_gouraud = 0;
    logic [23:0] cmd_color = '0;
    logic [31:0] in_data = '0;
    logic        in_valid = 0, seg_ready = 0;
    logic        in_ready, seg_valid, seg_point;
    logic [15:0] seg_x0, seg_y0, seg_x1, seg_y1;
    logic [23:0] seg_c0, seg_c1;

    int checks = 0, errors = 0, cyc = 0;
    // model of the list in progress
    int          m_cnt;
    logic        m_g;
    logic [23:0] m_cmdc, m_pc;
    logic [31:0] m_pp;

    polyline_parser uut (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, act %0d exp <150000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %0h exp %0h", req, act, exp);
        end
    endtask

    function automatic bit is_end(input logic [31:0] w);
        return (w & 32'hF000F000) == 32'h50005000;
    endfunction

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        in_data = w; in_valid = 1;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic start_list(input logic g, input logic [23:0] c);
        @(negedge clk);
        cmd_start = 1; cmd_gouraud = g; cmd_color = c;
        @(posedge clk); #1;
        cmd_start = 0;
        m_cnt = 0; m_g = g; m_cmdc = c;
        chk(in_ready === 1'b1, "R10 ready after start", {63'd0, in_ready}, 1);
    endtask

    task automatic vertex(input logic [23:0] col, input logic [31:0] pos);
        logic [23:0] newc;
        logic        pt;
        int          k;
        if (m_g) push({8'h00, col});
        push(pos);
        newc = m_g ? col : m_cmdc;
        if (m_cnt == 0) begin
            chk(seg_valid === 1'b0, "R4 no segment on first vertex", {63'd0, seg_valid}, 0);
        end else begin
            pt = (pos == m_pp);
            chk(seg_valid === 1'b1, "R4 segment after vertex", {63'd0, seg_valid}, 1);
            chk({seg_y0, seg_x0} === m_pp, "R1 start point", {32'd0, seg_y0, seg_x0}, {32'd0, m_pp});
            chk({seg_y1, seg_x1} === pos, "R1 end point", {32'd0, seg_y1, seg_x1}, {32'd0, pos});
            chk(seg_c0 === m_pc, m_g ? "R2 start colour" : "R3 start colour", {40'd0, seg_c0}, {40'd0, m_pc});
            chk(seg_c1 === (pt ? m_pc : newc), pt ? "R8 point colour" : (m_g ? "R2 end colour" : "R3 end colour"),
                {40'd0, seg_c1}, {40'd0, pt ? m_pc : newc});
            chk(seg_point === pt, "R8 point flag", {63'd0, seg_point}, {63'd0, pt});
            k = $urandom_range(0, 3);
            for (int i = 0; i < k; i++) begin
                @(negedge clk);
                chk(in_ready === 1'b0 && seg_valid === 1'b1 && {seg_y1, seg_x1} === pos,
                    "R9 stall holds", {31'd0, in_ready, seg_y1, seg_x1}, {32'd0, pos});
            end
            @(negedge clk); seg_ready = 1;
            @(posedge clk); #1; seg_ready = 0;
            chk(seg_valid === 1'b0, "R9 taken", {63'd0, seg_valid}, 0);
        end
        m_pp = pos; m_pc = newc; m_cnt++;
    endtask

    task automatic end_list();
        logic [31:0] w;
        w = ($urandom & 32'h0FFF0FFF) | 32'h50005000;
        push(w);
        chk(seg_valid === 1'b0, "R5 end word gives no segment", {63'd0, seg_valid}, 0);
        @(negedge clk); in_valid = 1; in_data = 32'h0001_0001;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(in_ready === 1'b0, "R10 idle after end", {63'd0, in_ready}, 0);
        end
        in_valid = 0;
    endtask

    function automatic logic [31:0] rand_pos(input bit allow_end);
        logic [31:0] p;
        p = {$urandom_range(0, 65535), 16'h0} | $urandom_range(0, 65535);
        while (!allow_end && is_end(p)) p = p ^ 32'h1000_0000;
        return p;
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk(in_ready === 1'b0, "R11 reset ready", {63'd0, in_ready}, 0);
        chk(seg_valid === 1'b0, "R11 reset valid", {63'd0, seg_valid}, 0);
        @(negedge clk); rst_n = 1;

        // flat: pattern word as first vertex is data (R6), duplicate point (R8), negative coords
        start_list(0, 24'hABCDEF);
        vertex(24'h0, 32'h5123_5456);
        vertex(24'h0, 32'hFFF6_0005);
        vertex(24'h0, 32'hFFF6_0005);
        end_list();

        // flat: pattern word as second vertex is still data (R6)
        start_list(0, 24'h112233);
        vertex(24'h0, 32'h0010_0020);
        vertex(24'h0, 32'h5000_5000);
        end_list();

        // gouraud: position word with pattern is data (R7), then point segment (R8)
        start_list(1, 24'h0);
        vertex(24'h00FF00, 32'h0003_0004);
        vertex(24'h0000FF, 32'h5555_5555);
        vertex(24'hFF0000, 32'h5555_5555);
        vertex(24'h123456, 32'h8000_7FFF);
        end_list();

        // random lists
        for (int n = 0; n < 40; n++) begin
            int nv;
            start_list($urandom_range(0, 1), $urandom_range(0, 24'hFFFFFF));
            nv = $urandom_range(2, 8);
            for (int v = 0; v < nv; v++) begin
                logic [31:0] p;
                p = rand_pos(m_g || m_cnt < 2);
                if (m_cnt > 0 && $urandom_range(0, 4) == 0) p = m_pp;
                vertex($urandom_range(0, 24'hFFFFFF), p);
            end
            end_list();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule